// File: doc/BRIEF.md
# Speculative Load Disambiguation Unit

This block keeps the memory operations of a small out-of-order core in program order and decides when a load may run before older stores whose addresses have not yet been computed. Operations enter in program order and each gets a slot tag. Each operation later gets its address from address generation. A load asks for permission to execute with its tag. If an older store still has no address, the load is let through only when a table of 2-bit alias counters, indexed by a fold of the load's instruction address, says the load is unlikely to collide.

Whenever a store address arrives, the block looks at every younger load that has already run on such a guess and that reads the same 8-byte block. The oldest of them is reported for replay one cycle later. Its counter is raised, and the load is barred from issuing again for a fixed cool-down. Entries leave in program order through a retire handshake, and a flush removes everything younger than a given tag. The allocation port is valid/ready. Allocation, retirement and issue are all refused while a flush is presented. The address writeback, issue request and flush pins are plain strobes that are taken in the cycle they are high.

Top module: `spec_load_guard`

## Requirements
- R1: alloc_ready is high when no flush is presented and fewer than 8 loads (alloc_store=0) or fewer than 8 stores (alloc_store=1) are held. Accepted operations get tags 0,1,2,… in allocation order, wrapping modulo 16, starting at 0 after reset.
- R2: After reset the block holds nothing. alloc_ready is 1, and replay_valid, issue_grant and retire_ready are 0.
- R3: issue_grant is high in the same cycle as issue_valid when all of the following hold: the tagged entry is a load, its address has been written, it has not executed, and its cool-down has ended. In addition, either no older store lacks an address, or the load's alias counter is below 2.
- R4: A load with an older address-less store and an alias counter of 2 or more is refused. Once every older store has its address it is granted, and a load that ran without bypassing is never reported for replay.
- R5: A store address writeback at cycle t compares address bits [31:3] with every younger load that executed by bypassing. If any match, replay_valid is high at cycle t+1 with replay_tag set to the oldest match. Older loads and loads in other blocks are never reported.
- R6: A reported load's alias counter, at index = XOR of the 4-bit chunks of its alloc_pc, rises by one and saturates at 3. All counters start at 0.
- R7: If replay_valid is high in cycle p, issue requests for that load are refused in cycles p..p+19 and granted from p+20.
- R8: Every 4096 cycles after reset all alias counters return to 0, so a previously blocked load index may bypass again.
- R9: retire_ready is high when the oldest entry is a store with its address, or a load that has executed and is not cooling down. A retire handshake frees that entry.
- R10: While flush_valid is high, alloc_ready, issue_grant and retire_ready are 0 and no replay is raised. Entries younger than flush_tag are dropped, and the next allocation gets tag flush_tag+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Allocation accepted this cycle when high with alloc_valid |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_pc | input | 16 | Instruction address of the operation |
| alloc_tag | output | 4 | Tag given to the operation being allocated |
| agu_valid | input | 1 | Address writeback strobe |
| agu_tag | input | 4 | Entry receiving the address |
| agu_addr | input | 32 | Computed byte address |
| issue_valid | input | 1 | Load issue request |
| issue_tag | input | 4 | Load asking to issue |
| issue_grant | output | 1 | Load may execute this cycle |
| retire_valid | input | 1 | Core wants to retire the oldest entry |
| retire_ready | output | 1 | Oldest entry may retire |
| replay_valid | output | 1 | Ordering violation found on the previous cycle's store address |
| replay_tag | output | 4 | Oldest violating load |
| flush_valid | input | 1 | Drop entries younger than flush_tag |
| flush_tag | input | 4 | Youngest surviving entry |

## Verification
The bench checks issue_grant, alloc_ready, alloc_tag and retire_ready in the cycle their inputs are driven, because these are combinational decisions. It samples them one nanosecond after the inputs change at the falling edge. The replay report is registered and is read at the falling edge right after the rising edge that took the store address. The cool-down is counted from that replay cycle: the bench issues requests at offsets 19 and 20, or at every offset from 0 to 20. A counter change from a replay shows up in the grant decision of the next load that uses that index.

// File: rtl/slg_pkg.sv
package slg_pkg;
  typedef logic [1:0] slg_ctr_t;
  localparam int SLG_CTR_MAX      = 3;
  localparam int SLG_BYPASS_LIMIT = 2;

  // distance of a ring slot from the oldest slot
  function automatic int slg_age(input int idx, input int head, input int depth);
    return (idx >= head) ? (idx - head) : (idx + depth - head);
  endfunction
endpackage

// File: rtl/slg_alias_pred.sv
module slg_alias_pred import slg_pkg::*; #(
  parameter int IDX_W        = 4,
  parameter int DECAY_PERIOD = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bypass,
  input  logic             trn_valid,
  input  logic [IDX_W-1:0] trn_idx
);
  localparam int N      = 1 << IDX_W;
  localparam int TICK_W = (DECAY_PERIOD > 1) ? $clog2(DECAY_PERIOD) : 1;

  slg_ctr_t          ctr [N];
  logic [TICK_W-1:0] tick_q;
  logic              decay_now;

  assign decay_now = (tick_q == TICK_W'(DECAY_PERIOD - 1));
  assign rd_bypass = (ctr[rd_idx] < slg_ctr_t'(SLG_BYPASS_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      for (int i = 0; i < N; i++) ctr[i] <= '0;
    end else begin
      tick_q <= decay_now ? '0 : tick_q + 1'b1;
      if (decay_now) begin
        for (int i = 0; i < N; i++) ctr[i] <= '0;
      end else if (trn_valid && ctr[trn_idx] != slg_ctr_t'(SLG_CTR_MAX)) begin
        ctr[trn_idx] <= ctr[trn_idx] + 2'd1;
      end
    end
  end

  // R6: a training pulse raises the counter by exactly one
  p_train_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_valid && !decay_now && ctr[trn_idx] != slg_ctr_t'(SLG_CTR_MAX))
      |=> (ctr[$past(trn_idx)] == $past(ctr[trn_idx]) + 2'd1));

  // R8: periodic clear empties the table
  p_decay_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    decay_now |=> (ctr[0] == '0 && ctr[N-1] == '0));
endmodule

// File: rtl/slg_conflict_scan.sv
module slg_conflict_scan import slg_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 29
) (
  input  logic                     en,
  input  logic [$clog2(DEPTH)-1:0] st_idx,
  input  logic [BLK_W-1:0]         st_blk,
  input  logic [$clog2(DEPTH)-1:0] head,
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0]         is_st,
  input  logic [DEPTH-1:0]         done,
  input  logic [DEPTH-1:0]         spec,
  input  logic [BLK_W-1:0]         blk [DEPTH],
  output logic                     hit,
  output logic [$clog2(DEPTH)-1:0] hit_idx
);
  localparam int IDX_W = $clog2(DEPTH);

  int st_age;

  // walk from youngest to oldest so the last match kept is the oldest
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    st_age  = slg_age(int'(st_idx), int'(head), DEPTH);
    for (int k = DEPTH - 1; k >= 0; k--) begin
      int i;
      i = (int'(head) + k) % DEPTH;
      if (en && vld[i] && !is_st[i] && done[i] && spec[i] &&
          k > st_age && blk[i] == st_blk) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard import slg_pkg::*; #(
  parameter int LD_SLOTS     = 8,
  parameter int ST_SLOTS     = 8,
  parameter int ADDR_W       = 32,
  parameter int PC_W         = 16,
  parameter int PRED_IDX_W   = 4,
  parameter int BLK_SHIFT    = 3,
  parameter int REPLAY_DELAY = 20,
  parameter int DECAY_PERIOD = 4096
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc_valid,
  output logic                             alloc_ready,
  input  logic                             alloc_store,
  input  logic [PC_W-1:0]                  alloc_pc,
  output logic [$clog2(LD_SLOTS+ST_SLOTS)-1:0] alloc_tag,
  input  logic                             agu_valid,
  input  logic [$clog2(LD_SLOTS+ST_SLOTS)-1:0] agu_tag,
  input  logic [ADDR_W-1:0]                agu_addr,
  input  logic                             issue_valid,
  input  logic [$clog2(LD_SLOTS+ST_SLOTS)-1:0] issue_tag,
  output logic                             issue_grant,
  input  logic                             retire_valid,
  output logic                             retire_ready,
  output logic                             replay_valid,
  output logic [$clog2(LD_SLOTS+ST_SLOTS)-1:0] replay_tag,
  input  logic                             flush_valid,
  input  logic [$clog2(LD_SLOTS+ST_SLOTS)-1:0] flush_tag
);
  localparam int DEPTH = LD_SLOTS + ST_SLOTS;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;
  localparam int TMR_W = $clog2(REPLAY_DELAY + 1);
  localparam int CNT_W = IDX_W + 1;

  function automatic logic [PRED_IDX_W-1:0] fold_pc(input logic [PC_W-1:0] pc);
    logic [PRED_IDX_W-1:0] f;
    f = '0;
    for (int c = 0; c < PC_W / PRED_IDX_W; c++) f ^= pc[c*PRED_IDX_W +: PRED_IDX_W];
    return f;
  endfunction

  function automatic logic [IDX_W-1:0] nxt_idx(input logic [IDX_W-1:0] x);
    return (int'(x) == DEPTH - 1) ? '0 : x + 1'b1;
  endfunction

  logic [DEPTH-1:0]      e_vld, e_st, e_aok, e_done, e_spec;
  logic [BLK_W-1:0]      e_blk  [DEPTH];
  logic [PRED_IDX_W-1:0] e_pidx [DEPTH];
  logic [TMR_W-1:0]      e_tmr  [DEPTH];
  logic [IDX_W-1:0]      head_q, tail_q;
  logic [CNT_W-1:0]      ld_cnt, st_cnt;

  logic                  older_unres, eligible, may_bypass;
  logic                  alloc_fire, retire_fire, scan_en, scan_hit;
  logic [IDX_W-1:0]      scan_idx;
  logic [DEPTH-1:0]      grant_vec, scan_done, scan_spec;
  logic                  unused_addr_lo;

  assign unused_addr_lo = ^agu_addr[BLK_SHIFT-1:0];

  // occupancy per kind
  always_comb begin
    ld_cnt = '0;
    st_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      ld_cnt = ld_cnt + CNT_W'(e_vld[i] & ~e_st[i]);
      st_cnt = st_cnt + CNT_W'(e_vld[i] & e_st[i]);
    end
  end

  assign alloc_ready = !flush_valid &&
                       (alloc_store ? (st_cnt < CNT_W'(ST_SLOTS)) : (ld_cnt < CNT_W'(LD_SLOTS)));
  assign alloc_tag   = tail_q;
  assign alloc_fire  = alloc_valid && alloc_ready;

  // issue decision
  always_comb begin
    older_unres = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (e_vld[j] && e_st[j] && !e_aok[j] &&
          slg_age(j, int'(head_q), DEPTH) < slg_age(int'(issue_tag), int'(head_q), DEPTH))
        older_unres = 1'b1;
    end
  end

  assign eligible    = e_vld[issue_tag] && !e_st[issue_tag] && e_aok[issue_tag] &&
                       !e_done[issue_tag] && (e_tmr[issue_tag] == '0);
  assign issue_grant = issue_valid && !flush_valid && eligible && (!older_unres || may_bypass);
  assign grant_vec   = issue_grant ? (DEPTH'(1) << issue_tag) : '0;
  assign scan_done   = e_done | grant_vec;
  assign scan_spec   = e_spec | (older_unres ? grant_vec : '0);

  assign retire_ready = !flush_valid && e_vld[head_q] &&
                        (e_st[head_q] ? e_aok[head_q] : (e_done[head_q] && e_tmr[head_q] == '0));
  assign retire_fire  = retire_valid && retire_ready;

  assign scan_en = agu_valid && !flush_valid && e_vld[agu_tag] && e_st[agu_tag];

  slg_alias_pred #(
    .IDX_W        (PRED_IDX_W),
    .DECAY_PERIOD (DECAY_PERIOD)
  ) u_pred (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (e_pidx[issue_tag]),
    .rd_bypass (may_bypass),
    .trn_valid (scan_hit),
    .trn_idx   (e_pidx[scan_idx])
  );

  slg_conflict_scan #(
    .DEPTH (DEPTH),
    .BLK_W (BLK_W)
  ) u_scan (
    .en      (scan_en),
    .st_idx  (agu_tag),
    .st_blk  (agu_addr[ADDR_W-1:BLK_SHIFT]),
    .head    (head_q),
    .vld     (e_vld),
    .is_st   (e_st),
    .done    (scan_done),
    .spec    (scan_spec),
    .blk     (e_blk),
    .hit     (scan_hit),
    .hit_idx (scan_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld        <= '0;
      e_st         <= '0;
      e_aok        <= '0;
      e_done       <= '0;
      e_spec       <= '0;
      head_q       <= '0;
      tail_q       <= '0;
      replay_valid <= 1'b0;
      replay_tag   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_blk[i]  <= '0;
        e_pidx[i] <= '0;
        e_tmr[i]  <= '0;
      end
    end else begin
      replay_valid <= scan_hit;
      replay_tag   <= scan_idx;
      for (int i = 0; i < DEPTH; i++) begin
        if (e_tmr[i] != '0) e_tmr[i] <= e_tmr[i] - 1'b1;
      end
      if (flush_valid) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (e_vld[i] && slg_age(i, int'(head_q), DEPTH) >
                          slg_age(int'(flush_tag), int'(head_q), DEPTH))
            e_vld[i] <= 1'b0;
        end
        tail_q <= nxt_idx(flush_tag);
      end else begin
        if (alloc_fire) begin
          e_vld[tail_q]  <= 1'b1;
          e_st[tail_q]   <= alloc_store;
          e_aok[tail_q]  <= 1'b0;
          e_done[tail_q] <= 1'b0;
          e_spec[tail_q] <= 1'b0;
          e_pidx[tail_q] <= fold_pc(alloc_pc);
          e_tmr[tail_q]  <= '0;
          tail_q         <= nxt_idx(tail_q);
        end
        if (agu_valid && e_vld[agu_tag]) begin
          e_aok[agu_tag] <= 1'b1;
          e_blk[agu_tag] <= agu_addr[ADDR_W-1:BLK_SHIFT];
        end
        if (issue_grant) begin
          e_done[issue_tag] <= 1'b1;
          e_spec[issue_tag] <= older_unres;
        end
        if (scan_hit) begin
          e_done[scan_idx] <= 1'b0;
          e_spec[scan_idx] <= 1'b0;
          e_tmr[scan_idx]  <= TMR_W'(REPLAY_DELAY);
        end
        if (retire_fire) begin
          e_vld[head_q] <= 1'b0;
          head_q        <= nxt_idx(head_q);
        end
      end
    end
  end

  // R7: the replayed load cannot be granted on the following cycle
  p_cooldown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |=> !(issue_grant && issue_tag == $past(replay_tag)));

  // R5: a reported entry is a live load whose execution was undone
  p_replay_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> (e_vld[replay_tag] && !e_st[replay_tag] && !e_done[replay_tag]));

  // R10: a flush cycle admits no other traffic
  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (!issue_grant && !alloc_ready && !retire_ready));

  // R9: a retire handshake frees the oldest slot
  p_retire_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && retire_ready) |=> !e_vld[$past(head_q)]);

  // R4: a load without an older open store is never refused for prediction reasons
  p_no_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !flush_valid && eligible && !older_unres) |-> issue_grant);
endmodule

// File: tb/spec_load_guard_test.sv
module spec_load_guard_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, alloc_store, alloc_ready;
  logic [15:0] alloc_pc;
  logic [3:0]  alloc_tag;
  logic        agu_valid;
  logic [3:0]  agu_tag;
  logic [31:0] agu_addr;
  logic        issue_valid, issue_grant;
  logic [3:0]  issue_tag;
  logic        retire_valid, retire_ready;
  logic        replay_valid;
  logic [3:0]  replay_tag;
  logic        flush_valid;
  logic [3:0]  flush_tag;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  int pm [16];

  always #4 clk = ~clk;

  spec_load_guard uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_store(alloc_store),
    .alloc_pc(alloc_pc), .alloc_tag(alloc_tag),
    .agu_valid(agu_valid), .agu_tag(agu_tag), .agu_addr(agu_addr),
    .issue_valid(issue_valid), .issue_tag(issue_tag), .issue_grant(issue_grant),
    .retire_valid(retire_valid), .retire_ready(retire_ready),
    .replay_valid(replay_valid), .replay_tag(replay_tag),
    .flush_valid(flush_valid), .flush_tag(flush_tag)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    alloc_valid = 0; alloc_store = 0; alloc_pc = '0;
    agu_valid = 0; agu_tag = '0; agu_addr = '0;
    issue_valid = 0; issue_tag = '0; retire_valid = 0;
    flush_valid = 0; flush_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) pm[i] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic alloc_op(input bit st, input logic [15:0] pc, output logic [3:0] tag, output bit rdy);
    alloc_valid = 1; alloc_store = st; alloc_pc = pc;
    #1; rdy = alloc_ready; tag = alloc_tag;
    @(posedge clk); @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic alloc_chk(input bit st, input logic [15:0] pc, output logic [3:0] tag);
    bit r;
    alloc_op(st, pc, tag, r);
    chk("R1 alloc_ready", r, 1);
  endtask

  task automatic agu_wb(input logic [3:0] tag, input logic [31:0] addr);
    agu_valid = 1; agu_tag = tag; agu_addr = addr;
    @(posedge clk); @(negedge clk);
    agu_valid = 0;
  endtask

  task automatic issue_try(input logic [3:0] tag, output bit g);
    issue_valid = 1; issue_tag = tag;
    #1; g = issue_grant;
    @(posedge clk); @(negedge clk);
    issue_valid = 0;
  endtask

  task automatic retire_try(output bit ok);
    retire_valid = 1;
    #1; ok = retire_ready;
    @(posedge clk); @(negedge clk);
    retire_valid = 0;
  endtask

  task automatic flush_to(input logic [3:0] tag, output bit ar);
    flush_valid = 1; flush_tag = tag;
    #1; ar = alloc_ready;
    @(posedge clk); @(negedge clk);
    flush_valid = 0;
  endtask

  function automatic bit same_blk(input logic [31:0] a, input logic [31:0] b);
    return a[31:3] == b[31:3];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] t0, t1, t2;
    bit g, ok, r;
    int unsigned sd;
    sd = $urandom(32'd4242);

    do_reset();
    // R2 reset state
    #1;
    chk("R2 alloc_ready", alloc_ready, 1);
    chk("R2 replay_valid", replay_valid, 0);
    chk("R2 retire_ready", retire_ready, 0);
    chk("R2 issue_grant", issue_grant, 0);

    // plain load, no older store (R1, R3, R9)
    alloc_chk(0, 16'd1, t0);
    chk("R1 first tag", t0, 0);
    agu_wb(t0, 32'h80);
    issue_try(t0, g); chk("R3 grant no older store", g, 1);
    retire_try(ok);   chk("R9 retire load", ok, 1);

    // violation, replay and cool-down (R3, R5, R6, R7)
    alloc_chk(1, 16'd0, t0);
    alloc_chk(0, 16'd5, t1);
    chk("R1 sequential tag", t1, (t0 + 1) % 16);
    agu_wb(t1, 32'h100);
    issue_try(t1, g); chk("R3 bypass granted", g, 1);
    agu_wb(t0, 32'h104);
    chk("R5 replay raised", replay_valid, 1);
    chk("R5 replay tag", replay_tag, t1);
    for (int k = 0; k <= 20; k++) begin
      issue_try(t1, g);
      chk("R7 cool-down window", g, (k == 20) ? 1 : 0);
    end
    retire_try(ok); chk("R9 retire store", ok, 1);
    retire_try(ok); chk("R9 retire replayed load", ok, 1);

    // older load and other block not reported (R5)
    alloc_chk(0, 16'd6, t0);
    alloc_chk(1, 16'd0, t1);
    alloc_chk(0, 16'd7, t2);
    agu_wb(t0, 32'h200); issue_try(t0, g); chk("R3 older load grant", g, 1);
    agu_wb(t2, 32'h300); issue_try(t2, g); chk("R3 younger bypass", g, 1);
    agu_wb(t1, 32'h208);
    chk("R5 no false replay", replay_valid, 0);
    for (int k = 0; k < 3; k++) begin retire_try(ok); chk("R9 retire", ok, 1); end

    // two violators: oldest reported; then flush (R5, R10)
    alloc_chk(1, 16'd0, t0);
    alloc_chk(0, 16'd8, t1);
    alloc_chk(0, 16'd9, t2);
    agu_wb(t1, 32'h400); issue_try(t1, g); chk("R3 grant a", g, 1);
    agu_wb(t2, 32'h404); issue_try(t2, g); chk("R3 grant b", g, 1);
    agu_wb(t0, 32'h400);
    chk("R5 replay on two", replay_valid, 1);
    chk("R5 oldest chosen", replay_tag, t1);
    flush_to(t0, r); chk("R10 alloc blocked in flush", r, 0);
    alloc_chk(0, 16'd10, t1);
    chk("R10 tag after flush", t1, (t0 + 1) % 16);
    agu_wb(t1, 32'h500); issue_try(t1, g); chk("R3 grant after flush", g, 1);
    retire_try(ok); chk("R9 retire", ok, 1);
    retire_try(ok); chk("R9 retire", ok, 1);

    // raise pc 5 counter to 2 (R6)
    alloc_chk(1, 16'd0, t0);
    alloc_chk(0, 16'd5, t1);
    agu_wb(t1, 32'h600); issue_try(t1, g); chk("R6 counter one still bypasses", g, 1);
    agu_wb(t0, 32'h600);
    chk("R5 replay second", replay_valid, 1);
    retire_try(ok); chk("R9 retire store", ok, 1);
    idle(18);
    issue_try(t1, g); chk("R7 refused at p+19", g, 0);
    issue_try(t1, g); chk("R7 granted at p+20", g, 1);
    retire_try(ok); chk("R9 retire", ok, 1);

    // held by predictor (R4, R6)
    alloc_chk(1, 16'd0, t0);
    alloc_chk(0, 16'd5, t1);
    agu_wb(t1, 32'h700);
    issue_try(t1, g); chk("R4 held at counter 2", g, 0);
    agu_wb(t0, 32'h700);
    chk("R4 held load not replayed", replay_valid, 0);
    issue_try(t1, g); chk("R4 granted after resolve", g, 1);
    retire_try(ok); chk("R9 retire", ok, 1);
    retire_try(ok); chk("R9 retire", ok, 1);

    // periodic clear (R8)
    idle(4200);
    alloc_chk(1, 16'd0, t0);
    alloc_chk(0, 16'd5, t1);
    agu_wb(t1, 32'h800);
    issue_try(t1, g); chk("R8 bypass after decay", g, 1);
    agu_wb(t0, 32'h900);
    chk("R5 other block no replay", replay_valid, 0);
    retire_try(ok); retire_try(ok);

    // capacity (R1)
    do_reset();
    for (int k = 0; k < 8; k++) begin
      alloc_chk(0, 16'(k), t0);
      chk("R1 tag order", t0, k);
    end
    alloc_valid = 1; alloc_store = 0; #1;
    chk("R1 ninth load refused", alloc_ready, 0);
    alloc_store = 1; #1;
    chk("R1 store still accepted", alloc_ready, 1);
    alloc_valid = 0;

    // constrained random rounds
    do_reset();
    for (int it = 0; it < 60; it++) begin
      logic [15:0] pc;
      logic [31:0] la, sa;
      bit exp_r;
      pc = 16'($urandom_range(0, 15));
      la = 32'h1000 + 32'(($urandom_range(0, 3) << 3) | $urandom_range(0, 7));
      sa = 32'h1000 + 32'(($urandom_range(0, 3) << 3) | $urandom_range(0, 7));
      alloc_chk(1, 16'd0, t0);
      alloc_chk(0, pc, t1);
      chk("R1 random tag", t1, (t0 + 1) % 16);
      agu_wb(t1, la);
      issue_try(t1, g);
      chk("R3 R4 random grant", g, (pm[pc] < 2) ? 1 : 0);
      agu_wb(t0, sa);
      exp_r = g && same_blk(la, sa);
      chk("R5 random replay", replay_valid, exp_r);
      if (exp_r) begin
        chk("R5 random tag", replay_tag, t1);
        if (pm[pc] < 3) pm[pc]++;
      end
      retire_try(ok); chk("R9 random store retire", ok, 1);
      if (!g) begin
        issue_try(t1, g); chk("R4 random late grant", g, 1);
      end else if (exp_r) begin
        idle(18);
        issue_try(t1, g); chk("R7 random refuse", g, 0);
        issue_try(t1, g); chk("R7 random grant", g, 1);
      end
      retire_try(ok); chk("R9 random load retire", ok, 1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule